// File: doc/BRIEF.md
# Coarse-Tick Watchdog with Early-Warning NMI

This block is a hardware watchdog that software reaches through a small memory-mapped register window. A 16-bit down-counter is loaded with a number of coarse ticks, and one tick lasts 128 ms. The tick length comes from a clock prescaler whose cycles-per-tick count is a parameter. Any write to the timer register reloads the count. This write is the keep-alive. A read of the same register returns the ticks that remain. A control byte starts and stops counting, arms an early-warning stage, and decides whether expiry drives the system reset output.

The early-warning stage fires when the count steps down to the tick value that corresponds to 9 seconds before expiry. With the default 128 ms tick this is 9000/128 = 70 ticks. At that point the block gives a one-cycle pulse on its NMI output and latches a status bit. Expiry latches a second status bit. The NMI handler reads both bits at a status byte to learn whether this block raised the interrupt. Software clears the status bits by writing 1 to them, or by reloading the timer.

Top module: `coarse_watchdog`

## Requirements
- R1: After reset the count, the control byte and both status bits read zero, and `nmi_out` and `sys_reset_out` are low.
- R2: The register window is decoded by halfword address. The status byte sits at 0x6E, the timer halfword at 0x70 and the control byte at 0x72; each byte register lives on bits 7:0. A byte access at an odd address uses bits 15:8. A read returns the whole aligned halfword. A halfword access at an odd address has no effect and reads 0. So does an access to any other halfword, or a byte access to the upper lane of the status or control halfword.
- R3: A halfword write to the timer loads all 16 bits. A byte write to the timer replaces only its own byte of the current count and reloads with the result. A read of the timer returns the remaining ticks.
- R4: Control bit 0 is run, bit 2 arms the early warning and bit 7 enables reset on expiry. The other bits read 0. Clearing bit 0 freezes the count at its current value. Bit 0 reads back as the running state.
- R5: While running, the count drops by one every CLKS_PER_TICK clock cycles. The first drop comes CLKS_PER_TICK cycles after the write that starts the timer or reloads it. The count saturates at 0 and holds there.
- R6: When the count steps from 71 to 70 with bit 2 set, `nmi_out` is high for exactly one cycle and status bit 1 sets. Nothing fires if bit 2 is clear, or if the count is loaded at 70 or below.
- R7: A tick that takes the count to 0, or that finds it at 0, sets status bit 2. If control bit 7 is set, it also raises `sys_reset_out`, which stays high until a reload or a stop. If bit 7 is clear, the reset output stays low.
- R8: Writing 1 to a status bit clears it, and a 0 leaves it alone. A reload clears both status bits and drops `sys_reset_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data, byte lanes chosen by address bit 0 |
| bus_rdata | output | 16 | Read data of the aligned halfword, valid in the access cycle |
| nmi_out | output | 1 | One-cycle early-warning pulse |
| sys_reset_out | output | 1 | Reset request after expiry |

## Verification
The bench targets the early-warning boundary: a load of exactly 70 must stay silent and a load of 71 must fire once. A decoder that compared with "at or below" would fire on every tick or on the load itself. The bench holds the count at zero for many ticks to show that it saturates rather than wrapping to 65535, which would postpone the reset by hours. It drives byte writes to each half of the timer, misaligned halfwords and upper-lane control writes. A lane or alignment error would corrupt the keep-alive value or change the control bits. Stop is done as a read-modify-write, and expiry is run with reset disabled, so that a reset that ignored bit 7 or outlived a stop would show on the output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DATA_W = 16;

  // control byte fields
  localparam int CTL_RUN_BIT = 0;
  localparam int CTL_PRE_BIT = 2;
  localparam int CTL_RST_BIT = 7;

  // status byte fields
  localparam int ST_PRE_BIT = 1;
  localparam int ST_EXP_BIT = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_TMR,
    SEL_CTL
  } reg_sel_e;

  typedef struct packed {
    logic rst_en;
    logic pre_en;
    logic run;
  } ctl_t;

  // one tick is 128 ms
  function automatic int secs_to_ticks(input int secs);
    return (secs * 1000) / 128;
  endfunction

  function automatic logic [1:0] lane_strobe(input logic half, input logic odd);
    if (half) return 2'b11;
    return odd ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [1:0]        strb);
    logic [DATA_W-1:0] r;
    r = old_w;
    if (strb[0]) r[7:0]  = new_w[7:0];
    if (strb[1]) r[15:8] = new_w[15:8];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctl(input ctl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTL_RUN_BIT] = c.run;
    w[CTL_PRE_BIT] = c.pre_en;
    w[CTL_RST_BIT] = c.rst_en;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic pre, input logic exp);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ST_PRE_BIT] = pre;
    w[ST_EXP_BIT] = exp;
    return w;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned CLKS_PER_TICK = 32_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  generate
    if (CLKS_PER_TICK <= 1) begin : g_every_cycle
      logic unused_pins;
      assign unused_pins = ^{clk, rst_n, restart};
      assign tick = run;
    end else begin : g_divider
      localparam int unsigned PW = $clog2(CLKS_PER_TICK);
      localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (restart || !run)  div_q <= '0;
        else if (div_q == LAST)    div_q <= '0;
        else                       div_q <= div_q + PW'(1);
      end

      assign tick = run && (div_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRE_TICKS = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             pre_hit,
  output logic             exp_hit
);

  localparam logic [CNT_W-1:0] PRE_NEXT = CNT_W'(PRE_TICKS + 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic step;
  logic at_floor;

  assign step     = tick && !load;
  assign at_floor = (cnt == '0) || (cnt == ONE);
  assign pre_hit  = step && (cnt == PRE_NEXT);
  assign exp_hit  = step && at_floor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (step)       cnt <= (cnt == '0) ? '0 : cnt - ONE;
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 8,
  parameter int unsigned      CNT_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h6E,
  parameter logic [ADDR_W-1:0] TMR_OFF  = 'h70,
  parameter logic [ADDR_W-1:0] CTL_OFF  = 'h72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              st_pre,
  input  logic              st_exp,
  output ctl_t              ctl,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic [1:0]        st_clr
);

  logic              odd;
  logic              aligned;
  logic [ADDR_W-1:0] hw_addr;
  logic [1:0]        strb;
  logic              wr;
  logic              rd;
  logic              ctl_wr;
  logic              stat_wr;
  reg_sel_e          sel;

  assign odd     = bus_addr[0];
  assign aligned = !(bus_half && odd);
  assign hw_addr = {bus_addr[ADDR_W-1:1], 1'b0};
  assign strb    = lane_strobe(bus_half, odd);
  assign wr      = bus_en && aligned && bus_we;
  assign rd      = bus_en && aligned && !bus_we;

  always_comb begin
    sel = SEL_NONE;
    if (hw_addr == STAT_OFF)     sel = SEL_STAT;
    else if (hw_addr == TMR_OFF) sel = SEL_TMR;
    else if (hw_addr == CTL_OFF) sel = SEL_CTL;
  end

  assign ctl_wr   = wr && (sel == SEL_CTL) && strb[0];
  assign stat_wr  = wr && (sel == SEL_STAT) && strb[0];
  assign load     = wr && (sel == SEL_TMR);
  assign load_val = CNT_W'(merge_lanes(DATA_W'(cnt), bus_wdata, strb));

  assign start_pulse = ctl_wr && bus_wdata[CTL_RUN_BIT] && !ctl.run;
  assign stop_pulse  = ctl_wr && !bus_wdata[CTL_RUN_BIT];
  assign st_clr      = stat_wr ? {bus_wdata[ST_EXP_BIT], bus_wdata[ST_PRE_BIT]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (ctl_wr) begin
      ctl.run    <= bus_wdata[CTL_RUN_BIT];
      ctl.pre_en <= bus_wdata[CTL_PRE_BIT];
      ctl.rst_en <= bus_wdata[CTL_RST_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (sel)
        SEL_STAT: bus_rdata = pack_status(st_pre, st_exp);
        SEL_TMR:  bus_rdata = DATA_W'(cnt);
        SEL_CTL:  bus_rdata = pack_ctl(ctl);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/coarse_watchdog.sv
module coarse_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 8,
  parameter int unsigned       CNT_W         = 16,
  parameter int unsigned       CLKS_PER_TICK = 32_000_000,
  parameter int unsigned       PRE_SECS      = 9,
  parameter logic [ADDR_W-1:0] STAT_OFF      = 'h6E,
  parameter logic [ADDR_W-1:0] TMR_OFF       = 'h70,
  parameter logic [ADDR_W-1:0] CTL_OFF       = 'h72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              nmi_out,
  output logic              sys_reset_out
);

  localparam int unsigned PRE_TICKS = unsigned'(secs_to_ticks(int'(PRE_SECS)));

  ctl_t             ctl;
  logic             running;
  logic             tick;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             start_pulse;
  logic             stop_pulse;
  logic             pre_hit;
  logic             exp_hit;
  logic [1:0]       st_clr;
  logic             st_pre;
  logic             st_exp;

  assign running = ctl.run;

  wdt_regs #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .STAT_OFF(STAT_OFF),
    .TMR_OFF (TMR_OFF),
    .CTL_OFF (CTL_OFF)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_half   (bus_half),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cnt        (cnt),
    .st_pre     (st_pre),
    .st_exp     (st_exp),
    .ctl        (ctl),
    .load       (load),
    .load_val   (load_val),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .st_clr     (st_clr)
  );

  wdt_prescaler #(
    .CLKS_PER_TICK(CLKS_PER_TICK)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (running),
    .restart(load || start_pulse),
    .tick   (tick)
  );

  wdt_countdown #(
    .CNT_W    (CNT_W),
    .PRE_TICKS(PRE_TICKS)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (load),
    .load_val(load_val),
    .cnt     (cnt),
    .pre_hit (pre_hit),
    .exp_hit (exp_hit)
  );

  // event flags: reload clears, events set, write-1 clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_out       <= 1'b0;
      st_pre        <= 1'b0;
      st_exp        <= 1'b0;
      sys_reset_out <= 1'b0;
    end else begin
      nmi_out <= pre_hit && ctl.pre_en;

      if (load)                         st_pre <= 1'b0;
      else if (pre_hit && ctl.pre_en)   st_pre <= 1'b1;
      else if (st_clr[0])               st_pre <= 1'b0;

      if (load)                         st_exp <= 1'b0;
      else if (exp_hit)                 st_exp <= 1'b1;
      else if (st_clr[1])               st_exp <= 1'b0;

      if (load || stop_pulse)           sys_reset_out <= 1'b0;
      else if (exp_hit && ctl.rst_en)   sys_reset_out <= 1'b1;
    end
  end

endmodule

// File: rtl/coarse_watchdog_chk.sv
module coarse_watchdog_chk #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRE_TICKS = 70
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic             nmi_out,
  input logic             sys_reset_out,
  input logic             st_pre,
  input logic             st_exp
);

  // R5
  count_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt <= $past(cnt));

  // R5
  count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> cnt == '0);

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(cnt));

  // R6
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |=> !nmi_out);

  // R6
  nmi_at_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> (cnt == CNT_W'(PRE_TICKS) && st_pre));

  // R7
  reset_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_out) |-> (cnt == '0 && st_exp));

  // R8
  reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!st_pre && !st_exp && !sys_reset_out));

endmodule

bind coarse_watchdog coarse_watchdog_chk #(
  .CNT_W    (CNT_W),
  .PRE_TICKS(PRE_TICKS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load         (load),
  .running      (running),
  .cnt          (cnt),
  .nmi_out      (nmi_out),
  .sys_reset_out(sys_reset_out),
  .st_pre       (st_pre),
  .st_exp       (st_exp)
);

// File: tb/coarse_watchdog_bench.sv
`timescale 1ns/1ps
module coarse_watchdog_bench;

  localparam int CPT     = 4;
  localparam int MARK    = 70;
  localparam int MAX_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_half = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        nmi_out;
  logic        sys_reset_out;

  int vec = 0;
  int bad = 0;
  int nmi_seen = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  coarse_watchdog #(.CLKS_PER_TICK(CPT)) u_coarse_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .nmi_out(nmi_out), .sys_reset_out(sys_reset_out)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt, m_pdiv;
  bit m_run, m_pre_en, m_rst_en, m_spre, m_sexp, m_nmi, m_rst;

  function automatic logic [15:0] model_read(bit half, logic [7:0] a);
    logic [7:0] hw;
    if (half && a[0]) return 16'h0;
    hw = a & 8'hFE;
    if (hw == 8'h6E) return 16'(m_sexp) * 4 + 16'(m_spre) * 2;
    if (hw == 8'h70) return 16'(m_cnt);
    if (hw == 8'h72) return 16'(m_rst_en) * 128 + 16'(m_pre_en) * 4 + 16'(m_run);
    return 16'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pdiv = 0; m_run = 0; m_pre_en = 0; m_rst_en = 0;
      m_spre = 0; m_sexp = 0; m_nmi = 0; m_rst = 0;
    end else begin
      bit ok, wr, low, high, ld, st, sp, tk, ph, eh, clr_p, clr_e, ctlw;
      logic [7:0] hw;
      int nc;
      ok   = !(bus_half && bus_addr[0]);
      wr   = bus_en && bus_we && ok;
      hw   = bus_addr & 8'hFE;
      low  = bus_half || !bus_addr[0];
      high = bus_half || bus_addr[0];
      ld   = wr && hw == 8'h70;
      ctlw = wr && hw == 8'h72 && low;
      st   = ctlw && bus_wdata[0] && !m_run;
      sp   = ctlw && !bus_wdata[0];
      clr_p = wr && hw == 8'h6E && low && bus_wdata[1];
      clr_e = wr && hw == 8'h6E && low && bus_wdata[2];
      tk   = m_run && (m_pdiv == CPT - 1);
      ph   = tk && !ld && m_cnt == MARK + 1;
      eh   = tk && !ld && m_cnt <= 1;
      nc = m_cnt;
      if (ld) begin
        if (low)  nc = (nc & 32'hFF00) | int'(bus_wdata & 16'h00FF);
        if (high) nc = (nc & 32'h00FF) | int'(bus_wdata & 16'hFF00);
      end else if (tk && nc > 0) nc = nc - 1;
      if (ld || st || !m_run) m_pdiv = 0;
      else if (m_pdiv == CPT - 1) m_pdiv = 0;
      else m_pdiv = m_pdiv + 1;
      m_nmi = ph && m_pre_en;
      if (ld) m_spre = 0; else if (ph && m_pre_en) m_spre = 1; else if (clr_p) m_spre = 0;
      if (ld) m_sexp = 0; else if (eh) m_sexp = 1; else if (clr_e) m_sexp = 0;
      if (ld || sp) m_rst = 0; else if (eh && m_rst_en) m_rst = 1;
      if (ctlw) begin
        m_run = bus_wdata[0]; m_pre_en = bus_wdata[2]; m_rst_en = bus_wdata[7];
      end
      m_cnt = nc;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vec++;
      if (nmi_out !== m_nmi) begin
        bad++;
        $display("FAIL R6 nmi_out actual %0b expected %0b", nmi_out, m_nmi);
      end
      vec++;
      if (sys_reset_out !== m_rst) begin
        bad++;
        $display("FAIL R7 sys_reset_out actual %0b expected %0b", sys_reset_out, m_rst);
      end
      if (bus_en && !bus_we) begin
        vec++;
        if (bus_rdata !== model_read(bus_half, bus_addr)) begin
          bad++;
          $display("FAIL R2 read data @%0h actual %0h expected %0h",
                   bus_addr, bus_rdata, model_read(bus_half, bus_addr));
        end
      end
      if (nmi_out) nmi_seen++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(bit half, logic [7:0] a, logic [15:0] d);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 1; bus_half = half; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_reg(bit half, logic [7:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 0; bus_half = half; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      bad++;
      $display("FAIL R5 watchdog expired: actual %0d cycles expected below %0d", cyc, MAX_CYC);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] d, t1;
    int n0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd_reg(1, 8'h72, d); chk("R1 control after reset", d, 16'h0000);
    rd_reg(1, 8'h70, d); chk("R1 timer after reset", d, 16'h0000);
    rd_reg(0, 8'h6E, d); chk("R1 status after reset", d, 16'h0000);
    chk("R1 outputs after reset", {nmi_out, sys_reset_out}, 2'b00);

    // R3 load while stopped
    wr_reg(1, 8'h70, 16'd200);
    rd_reg(1, 8'h70, d); chk("R3 timer readback", d, 16'd200);

    // R4 start with reset and early warning armed
    wr_reg(0, 8'h72, 16'h0085);
    rd_reg(0, 8'h72, d); chk("R4 control readback", d, 16'h0085);

    // R6 early warning
    for (int i = 0; i < 2000 && !nmi_out; i++) @(negedge clk);
    chk("R6 nmi pulse seen", nmi_out, 1'b1);
    rd_reg(1, 8'h70, d); chk("R6 count at warning", d, 16'd70);
    rd_reg(0, 8'h6E, d); chk("R6 status after warning", d, 16'h0002);

    // R7 expiry with reset enabled
    for (int i = 0; i < 2000 && !sys_reset_out; i++) @(negedge clk);
    chk("R7 reset raised", sys_reset_out, 1'b1);
    rd_reg(1, 8'h70, d); chk("R5 count saturated", d, 16'd0);
    rd_reg(0, 8'h6E, d); chk("R7 status after expiry", d, 16'h0006);
    idle(40);
    @(negedge clk);
    chk("R7 reset held", sys_reset_out, 1'b1);
    rd_reg(1, 8'h70, d); chk("R5 count holds at zero", d, 16'd0);

    // R8 write-1-clear of one bit
    wr_reg(0, 8'h6E, 16'h0002);
    rd_reg(0, 8'h6E, d); chk("R8 w1c clears only bit 1", d, 16'h0004);

    // R8 reload clears
    wr_reg(1, 8'h70, 16'd150);
    rd_reg(0, 8'h6E, d); chk("R8 status cleared by reload", d, 16'h0000);
    chk("R8 reset dropped by reload", sys_reset_out, 1'b0);
    rd_reg(1, 8'h70, d); chk("R3 reload value", d, 16'd150);

    // R4 stop by read-modify-write
    rd_reg(0, 8'h72, d);
    wr_reg(0, 8'h72, d & 16'h00FE);
    rd_reg(0, 8'h72, d); chk("R4 stopped control", d, 16'h0084);
    rd_reg(1, 8'h70, t1);
    idle(40);
    rd_reg(1, 8'h70, d); chk("R4 count frozen", d, t1);

    // R7 expiry with reset disabled
    wr_reg(0, 8'h72, 16'h0001);
    wr_reg(1, 8'h70, 16'd5);
    idle(60);
    @(negedge clk);
    chk("R7 no reset when bit 7 clear", sys_reset_out, 1'b0);
    rd_reg(0, 8'h6E, d); chk("R7 expiry flag only", d, 16'h0004);

    // R6 boundary: load at the mark stays silent
    wr_reg(0, 8'h72, 16'h0005);
    n0 = nmi_seen;
    wr_reg(1, 8'h70, 16'd70);
    idle(400);
    chk("R6 load of 70 silent", nmi_seen, n0);
    wr_reg(1, 8'h70, 16'd71);
    idle(12);
    chk("R6 load of 71 fires once", nmi_seen, n0 + 1);

    // R6 early warning disarmed
    wr_reg(0, 8'h72, 16'h0001);
    n0 = nmi_seen;
    wr_reg(1, 8'h70, 16'd80);
    idle(80);
    chk("R6 disarmed no pulse", nmi_seen, n0);
    rd_reg(0, 8'h6E, d); chk("R6 disarmed no status", d, 16'h0000);

    // R3 byte writes while stopped
    wr_reg(0, 8'h72, 16'h0000);
    wr_reg(0, 8'h71, 16'hAB00);
    wr_reg(0, 8'h70, 16'h00CD);
    rd_reg(1, 8'h70, d); chk("R3 byte-merged count", d, 16'hABCD);
    rd_reg(0, 8'h71, d); chk("R2 byte read returns halfword", d, 16'hABCD);

    // R2 ignored accesses
    wr_reg(1, 8'h71, 16'h1234);
    rd_reg(1, 8'h70, d); chk("R2 misaligned write ignored", d, 16'hABCD);
    wr_reg(1, 8'h74, 16'hFFFF);
    rd_reg(1, 8'h74, d); chk("R2 unmapped reads zero", d, 16'h0000);
    rd_reg(1, 8'h73, d); chk("R2 misaligned read zero", d, 16'h0000);
    wr_reg(0, 8'h73, 16'hFF00);
    rd_reg(0, 8'h72, d); chk("R2 upper lane of control ignored", d, 16'h0000);

    // R5 tick period from start
    wr_reg(1, 8'h70, 16'd10);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 1; bus_half = 0; bus_addr = 8'h72; bus_wdata = 16'h0001;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
    idle(5 * CPT);
    rd_reg(1, 8'h70, d); chk("R5 five ticks elapsed", d, 16'd5);

    idle(4);
    finish_run();
  end

endmodule